// File: doc/BRIEF.md
# Write-Through Replicated Memory Packet Engine

This block sits on one node of a cluster and keeps a small word-addressed memory window coherent with the same window on every other node. A local store is written into the node's own memory and, one cycle later, appears on the transmit side as a fixed three-word packet. That packet carries the word address, the byte-lane mask, the data, the sender's node ID and a one-byte checksum. The network side delivers packets from other nodes. A data packet with a correct checksum performs a byte-masked write into the same word of the local window. A broadcast packet lands on every node. A unicast packet lands only on the node named in its receiver byte.

Local reads are served from the local memory alone and never produce traffic. Packets whose type is not data are handed unchanged to a side output for other logic. Packets with a corrupt checksum are thrown away and tallied in a saturating error counter.

The environment presents at most one local write in any two consecutive cycles, and at most one received packet in any two consecutive cycles. A serial link needs several word times per packet anyway. The node's own ID lies in 1..254, so the receiver values 0 and 255 address no node.

Top module: `wtmem_pkt_engine`

## Requirements
- R1: A local write (`lw_valid`) updates only the byte lanes whose `lw_be` bit is set, with bit 0 selecting data bits 7:0 and bit 3 selecting bits 31:24. A later local read of that word returns the merged value.
- R2: The cycle after a local write, `tx_valid` is high for exactly one cycle. `tx_pkt` holds word 0 in bits 95:64, word 1 in bits 63:32 and word 2 in bits 31:0. Word 1 is {byte mask[3:0], 28-bit word address zero-extended from `lw_addr`}, and word 2 is the write data.
- R3: Word 0 of a transmitted packet is {checksum[7:0], control[7:0], sender[7:0], receiver[7:0]}. The sender is `node_id`. Control bits 3:0 carry the data type code 4'h1 and control bit 4 is 1 for unicast. For unicast the receiver byte is `lw_dest`; for broadcast it is 0.
- R4: The checksum byte is chosen so that the 8-bit sum of all twelve packet bytes is zero.
- R5: A received packet whose twelve bytes do not sum to zero (mod 256) has no effect on memory or on the side output, and it raises `err_cnt` by one. The counter sticks at its all-ones value.
- R6: A received data packet (type 4'h1) with a correct checksum and control bit 4 clear writes only the byte lanes set in its word-1 mask into the addressed local word.
- R7: A received unicast data packet (control bit 4 set) is applied only when its receiver byte equals `node_id`. Any other receiver value leaves memory unchanged.
- R8: A received packet of any type other than 4'h1, with a correct checksum, appears unchanged on `side_pkt` with `side_valid` high for one cycle, in the cycle after it arrives. It does not alter memory.
- R9: When a local write and an applicable received data packet arrive in the same cycle, the local write is applied first and the received write one cycle later. Bytes written by both therefore end up holding the received data.
- R10: A local read (`lr_en`) returns the stored word on `lr_data` in the next cycle, and it causes no transmit packet.
- R11: A received data packet whose 28-bit address has any bit set above the window width is ignored.
- R12: After reset, `tx_valid`, `side_valid` and `err_cnt` are zero and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 8 | This node's ID, 1..254 |
| lw_valid | input | 1 | Local write strobe |
| lw_ucast | input | 1 | Send the mirrored packet as unicast |
| lw_dest | input | 8 | Receiver ID for a unicast mirror |
| lw_addr | input | ADDR_W | Local word address |
| lw_be | input | 4 | Local byte-lane mask |
| lw_data | input | 32 | Local write data |
| lr_en | input | 1 | Local read strobe |
| lr_addr | input | ADDR_W | Local read address |
| lr_data | output | 32 | Read data, one cycle after `lr_en` |
| tx_valid | output | 1 | Outgoing packet strobe |
| tx_pkt | output | 96 | Outgoing three-word packet |
| rx_valid | input | 1 | Incoming packet strobe |
| rx_pkt | input | 96 | Incoming three-word packet |
| side_valid | output | 1 | Non-data packet strobe |
| side_pkt | output | 96 | Forwarded non-data packet |
| err_cnt | output | ERR_W | Saturating checksum-error count |

## Verification
Some corner cases concern received packets. Partial masks must not disturb the unselected lanes; a design that wrote full words would wipe neighbouring bytes. Unicast packets addressed to another node must leave memory unchanged; a design that ignored the receiver byte would let one node corrupt another's data. A non-data packet must reach the side output and never touch memory, and an address with bits above the window must be refused; a design that truncated that address would alias it onto a low word.

The same-cycle collision is probed by reading the contested word in the cycle between the two writes and again afterwards. A design that dropped the held packet, or applied it before the local write, would leave the wrong final bytes. Corrupt packets are sent both as data and as non-data, and then long enough to push the error counter past its ceiling. A wrapping counter would return to zero.

// File: rtl/wtmem_pkg.sv
package wtmem_pkg;

    localparam int WORD_W      = 32;
    localparam int BE_W        = WORD_W / 8;
    localparam int PKT_ADDR_W  = 28;
    localparam int ID_W        = 8;
    localparam int PKT_BYTES   = 12;

    localparam logic [3:0] PT_DATA = 4'h1;
    localparam int CTRL_UCAST_BIT  = 4;

    typedef struct packed {
        logic [7:0]            chk;
        logic [7:0]            ctrl;
        logic [ID_W-1:0]       sender;
        logic [ID_W-1:0]       rcvr;
        logic [BE_W-1:0]       mask;
        logic [PKT_ADDR_W-1:0] addr;
        logic [WORD_W-1:0]     data;
    } upkt_t;

    // Sum of the eleven bytes that the checksum protects.
    function automatic logic [7:0] body_sum(upkt_t p);
        logic [8*PKT_BYTES-1:0] v;
        logic [7:0] s;
        v = p;
        s = '0;
        for (int i = 0; i < PKT_BYTES - 1; i++) begin
            s = s + v[i*8 +: 8];
        end
        return s;
    endfunction

    function automatic logic [7:0] make_chk(upkt_t p);
        return 8'(8'd0 - body_sum(p));
    endfunction

    function automatic logic chk_ok(upkt_t p);
        return 8'(body_sum(p) + p.chk) == 8'd0;
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(
        logic [WORD_W-1:0] old_w,
        logic [WORD_W-1:0] new_w,
        logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] r;
        for (int b = 0; b < BE_W; b++) begin
            r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/wtmem_tx_build.sv
module wtmem_tx_build
    import wtmem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ID_W-1:0]      node_id,
    input  logic                 lw_valid,
    input  logic                 lw_ucast,
    input  logic [ID_W-1:0]      lw_dest,
    input  logic [ADDR_W-1:0]    lw_addr,
    input  logic [BE_W-1:0]      lw_be,
    input  logic [WORD_W-1:0]    lw_data,
    output logic                 tx_valid,
    output upkt_t                tx_pkt
);

    upkt_t pkt_c;

    always_comb begin
        pkt_c        = '0;
        pkt_c.ctrl   = '0;
        pkt_c.ctrl[3:0]            = PT_DATA;
        pkt_c.ctrl[CTRL_UCAST_BIT] = lw_ucast;
        pkt_c.sender = node_id;
        pkt_c.rcvr   = lw_ucast ? lw_dest : '0;
        pkt_c.mask   = lw_be;
        pkt_c.addr   = PKT_ADDR_W'(lw_addr);
        pkt_c.data   = lw_data;
        pkt_c.chk    = make_chk(pkt_c);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_pkt   <= '0;
        end else begin
            tx_valid <= lw_valid;
            if (lw_valid) begin
                tx_pkt <= pkt_c;
            end
        end
    end

endmodule

// File: rtl/wtmem_rx_parse.sv
module wtmem_rx_parse
    import wtmem_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int ERR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ID_W-1:0]      node_id,
    input  logic                 rx_valid,
    input  upkt_t                rx_pkt,
    output logic                 wr_vld,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [BE_W-1:0]      wr_be,
    output logic [WORD_W-1:0]    wr_data,
    output logic                 side_valid,
    output upkt_t                side_pkt,
    output logic [ERR_W-1:0]     err_cnt
);

    logic sum_good;
    logic is_data;
    logic for_me;
    logic in_win;

    generate
        if (ADDR_W < PKT_ADDR_W) begin : g_win
            assign in_win = (rx_pkt.addr[PKT_ADDR_W-1:ADDR_W] == '0);
        end else begin : g_full
            assign in_win = 1'b1;
        end
    endgenerate

    always_comb begin
        sum_good = chk_ok(rx_pkt);
        is_data  = (rx_pkt.ctrl[3:0] == PT_DATA);
        for_me   = !rx_pkt.ctrl[CTRL_UCAST_BIT] || (rx_pkt.rcvr == node_id);
        wr_vld   = rx_valid && sum_good && is_data && for_me && in_win;
        wr_addr  = rx_pkt.addr[ADDR_W-1:0];
        wr_be    = rx_pkt.mask;
        wr_data  = rx_pkt.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_valid <= 1'b0;
            side_pkt   <= '0;
            err_cnt    <= '0;
        end else begin
            side_valid <= rx_valid && sum_good && !is_data;
            if (rx_valid && sum_good && !is_data) begin
                side_pkt <= rx_pkt;
            end
            if (rx_valid && !sum_good && (err_cnt != '1)) begin
                err_cnt <= err_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wtmem_store.sv
module wtmem_store
    import wtmem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 l_vld,
    input  logic [ADDR_W-1:0]    l_addr,
    input  logic [BE_W-1:0]      l_be,
    input  logic [WORD_W-1:0]    l_data,
    input  logic                 r_vld,
    input  logic [ADDR_W-1:0]    r_addr,
    input  logic [BE_W-1:0]      r_be,
    input  logic [WORD_W-1:0]    r_data,
    input  logic                 lr_en,
    input  logic [ADDR_W-1:0]    lr_addr,
    output logic [WORD_W-1:0]    lr_data,
    output logic                 hold_vld
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    logic [ADDR_W-1:0] hold_addr;
    logic [BE_W-1:0]   hold_be;
    logic [WORD_W-1:0] hold_data;

    logic              w_vld;
    logic [ADDR_W-1:0] w_addr;
    logic [BE_W-1:0]   w_be;
    logic [WORD_W-1:0] w_data;

    // Port priority: local store, then a held packet, then a fresh packet.
    always_comb begin
        if (l_vld) begin
            w_vld = 1'b1;  w_addr = l_addr;    w_be = l_be;    w_data = l_data;
        end else if (hold_vld) begin
            w_vld = 1'b1;  w_addr = hold_addr; w_be = hold_be; w_data = hold_data;
        end else begin
            w_vld = r_vld; w_addr = r_addr;    w_be = r_be;    w_data = r_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            lr_data   <= '0;
            hold_vld  <= 1'b0;
            hold_addr <= '0;
            hold_be   <= '0;
            hold_data <= '0;
        end else begin
            if (w_vld) begin
                mem[w_addr] <= lane_merge(mem[w_addr], w_data, w_be);
            end
            if (lr_en) begin
                lr_data <= mem[lr_addr];
            end
            if (r_vld && (l_vld || hold_vld)) begin
                hold_vld  <= 1'b1;
                hold_addr <= r_addr;
                hold_be   <= r_be;
                hold_data <= r_data;
            end else if (!l_vld) begin
                hold_vld  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wtmem_pkt_engine.sv
module wtmem_pkt_engine
    import wtmem_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        node_id,
    input  logic              lw_valid,
    input  logic              lw_ucast,
    input  logic [7:0]        lw_dest,
    input  logic [ADDR_W-1:0] lw_addr,
    input  logic [3:0]        lw_be,
    input  logic [31:0]       lw_data,
    input  logic              lr_en,
    input  logic [ADDR_W-1:0] lr_addr,
    output logic [31:0]       lr_data,
    output logic              tx_valid,
    output logic [95:0]       tx_pkt,
    input  logic              rx_valid,
    input  logic [95:0]       rx_pkt,
    output logic              side_valid,
    output logic [95:0]       side_pkt,
    output logic [ERR_W-1:0]  err_cnt
);

    upkt_t             tx_p;
    upkt_t             rx_p;
    upkt_t             side_p;
    logic              rw_vld;
    logic [ADDR_W-1:0] rw_addr;
    logic [BE_W-1:0]   rw_be;
    logic [WORD_W-1:0] rw_data;
    logic              hold_vld;

    assign rx_p     = upkt_t'(rx_pkt);
    assign tx_pkt   = tx_p;
    assign side_pkt = side_p;

    wtmem_tx_build #(.ADDR_W(ADDR_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .node_id  (node_id),
        .lw_valid (lw_valid),
        .lw_ucast (lw_ucast),
        .lw_dest  (lw_dest),
        .lw_addr  (lw_addr),
        .lw_be    (lw_be),
        .lw_data  (lw_data),
        .tx_valid (tx_valid),
        .tx_pkt   (tx_p)
    );

    wtmem_rx_parse #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .node_id    (node_id),
        .rx_valid   (rx_valid),
        .rx_pkt     (rx_p),
        .wr_vld     (rw_vld),
        .wr_addr    (rw_addr),
        .wr_be      (rw_be),
        .wr_data    (rw_data),
        .side_valid (side_valid),
        .side_pkt   (side_p),
        .err_cnt    (err_cnt)
    );

    wtmem_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .l_vld    (lw_valid),
        .l_addr   (lw_addr),
        .l_be     (lw_be),
        .l_data   (lw_data),
        .r_vld    (rw_vld),
        .r_addr   (rw_addr),
        .r_be     (rw_be),
        .r_data   (rw_data),
        .lr_en    (lr_en),
        .lr_addr  (lr_addr),
        .lr_data  (lr_data),
        .hold_vld (hold_vld)
    );

endmodule

// File: rtl/wtmem_checker.sv
module wtmem_checker
    import wtmem_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             lw_valid,
    input logic             rx_valid,
    input logic [95:0]      rx_pkt,
    input logic             tx_valid,
    input logic [95:0]      tx_pkt,
    input logic             side_valid,
    input logic [ERR_W-1:0] err_cnt,
    input logic             hold_vld
);

    upkt_t txp;
    upkt_t rxp;
    assign txp = upkt_t'(tx_pkt);
    assign rxp = upkt_t'(rx_pkt);

    // R2: every local write yields a packet in the next cycle
    p_tx_after_write_r2: assert property (@(posedge clk) disable iff (rst)
        lw_valid |=> tx_valid);

    // R10: no packet without a preceding local write (reads create none)
    p_tx_needs_write_r10: assert property (@(posedge clk) disable iff (rst)
        !lw_valid |=> !tx_valid);

    // R4: emitted packets sum to zero over all bytes
    p_tx_chk_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> chk_ok(txp));

    // R3: emitted packets carry the data type code
    p_tx_type_r3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (txp.ctrl[3:0] == PT_DATA));

    // R5: error count moves by at most one per cycle
    p_err_step_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_cnt == $past(err_cnt)) || (err_cnt == ERR_W'($past(err_cnt) + 1'b1)));

    // R5: a corrupt packet below saturation bumps the count
    p_err_bump_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !chk_ok(rxp) && (err_cnt != '1)) |=> (err_cnt == ERR_W'($past(err_cnt) + 1'b1)));

    // R8: side output only follows a received packet
    p_side_needs_rx_r8: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !side_valid);

    // R9: a held packet is applied in the following cycle
    p_hold_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        hold_vld |=> !hold_vld);

    // R9: environment spacing that the one-cycle hold relies on
    p_lw_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        lw_valid |=> !lw_valid);
    p_rx_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

bind wtmem_pkt_engine wtmem_checker #(.ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lw_valid   (lw_valid),
    .rx_valid   (rx_valid),
    .rx_pkt     (rx_pkt),
    .tx_valid   (tx_valid),
    .tx_pkt     (tx_pkt),
    .side_valid (side_valid),
    .err_cnt    (err_cnt),
    .hold_vld   (hold_vld)
);

// File: tb/wtmem_pkt_engine_bench.sv
`timescale 1ns/1ps
module wtmem_pkt_engine_bench;

    localparam int ADDR_W = 6;
    localparam int ERR_W  = 8;
    localparam logic [7:0] NODE = 8'd7;

    logic              clk = 1'b0;
    logic              rst;
    logic              lw_valid, lw_ucast;
    logic [7:0]        lw_dest;
    logic [ADDR_W-1:0] lw_addr;
    logic [3:0]        lw_be;
    logic [31:0]       lw_data;
    logic              lr_en;
    logic [ADDR_W-1:0] lr_addr;
    logic [31:0]       lr_data;
    logic              tx_valid;
    logic [95:0]       tx_pkt;
    logic              rx_valid;
    logic [95:0]       rx_pkt;
    logic              side_valid;
    logic [95:0]       side_pkt;
    logic [ERR_W-1:0]  err_cnt;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    wtmem_pkt_engine #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_wtmem_pkt_engine (
        .clk(clk), .rst(rst), .node_id(NODE),
        .lw_valid(lw_valid), .lw_ucast(lw_ucast), .lw_dest(lw_dest),
        .lw_addr(lw_addr), .lw_be(lw_be), .lw_data(lw_data),
        .lr_en(lr_en), .lr_addr(lr_addr), .lr_data(lr_data),
        .tx_valid(tx_valid), .tx_pkt(tx_pkt),
        .rx_valid(rx_valid), .rx_pkt(rx_pkt),
        .side_valid(side_valid), .side_pkt(side_pkt), .err_cnt(err_cnt)
    );

    // {ucast, dest[7:0], addr[5:0], be[3:0], data[31:0], readback[31:0]}
    localparam int VW = 83;
    localparam int NV = 7;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 8'd0,   6'd3,  4'hF, 32'h12345678, 32'h12345678},
        {1'b0, 8'd0,   6'd3,  4'h3, 32'hAABBCCDD, 32'h1234CCDD},
        {1'b1, 8'd9,   6'd10, 4'h8, 32'h11223344, 32'h11000000},
        {1'b0, 8'd0,   6'd63, 4'h5, 32'hDEADBEEF, 32'h00AD00EF},
        {1'b1, 8'd254, 6'd0,  4'hF, 32'h00000000, 32'h00000000},
        {1'b0, 8'd0,   6'd10, 4'h6, 32'h55667788, 32'h11667700},
        {1'b0, 8'd0,   6'd3,  4'h0, 32'hFFFFFFFF, 32'h1234CCDD}
    };

    function automatic logic [7:0] sum11(logic [95:0] p);
        logic [7:0] s = 8'd0;
        for (int i = 0; i < 11; i++) s = s + p[i*8 +: 8];
        return s;
    endfunction

    function automatic logic [95:0] build(logic [3:0] ptype, logic uc, logic [7:0] snd,
                                          logic [7:0] rcv, logic [3:0] be, logic [27:0] a,
                                          logic [31:0] d, logic corrupt);
        logic [95:0] p;
        p = {8'd0, 3'b000, uc, ptype, snd, rcv, be, a, d};
        p[95:88] = 8'(8'd0 - sum11(p)) + (corrupt ? 8'd1 : 8'd0);
        return p;
    endfunction

    task automatic check(string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    logic tx_seen;
    logic [95:0] tx_seen_pkt;

    task automatic local_write(logic uc, logic [7:0] dst, logic [ADDR_W-1:0] a,
                               logic [3:0] be, logic [31:0] d);
        lw_valid = 1'b1; lw_ucast = uc; lw_dest = dst; lw_addr = a; lw_be = be; lw_data = d;
        @(negedge clk);
        tx_seen = tx_valid; tx_seen_pkt = tx_pkt;
        lw_valid = 1'b0;
        @(negedge clk);
    endtask

    logic [31:0] rd;
    logic        rd_tx;
    task automatic read_word(logic [ADDR_W-1:0] a);
        lr_en = 1'b1; lr_addr = a;
        @(negedge clk);
        rd = lr_data; rd_tx = tx_valid;
        lr_en = 1'b0;
    endtask

    logic        s_valid, s_valid_after;
    logic [95:0] s_pkt;
    task automatic send_rx(logic [95:0] p);
        rx_valid = 1'b1; rx_pkt = p;
        @(negedge clk);
        s_valid = side_valid; s_pkt = side_pkt;
        rx_valid = 1'b0;
        @(negedge clk);
        s_valid_after = side_valid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; lw_valid = 0; lw_ucast = 0; lw_dest = 0; lw_addr = 0; lw_be = 0;
        lw_data = 0; lr_en = 0; lr_addr = 0; rx_valid = 0; rx_pkt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check("R12 tx_valid", 96'(tx_valid), 96'd0);
        check("R12 side_valid", 96'(side_valid), 96'd0);
        check("R12 err_cnt", 96'(err_cnt), 96'd0);
        read_word(6'd5);
        check("R12 mem", 96'(rd), 96'd0);
        idle(1);

        // R1 R2 R3 R4 R10: vector table of local writes
        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            logic [95:0] e;
            v = VEC[k];
            local_write(v[82], v[81:74], v[73:68], v[67:64], v[63:32]);
            e = build(4'h1, v[82], NODE, v[82] ? v[81:74] : 8'd0, v[67:64],
                      28'(v[73:68]), v[63:32], 1'b0);
            check("R2 tx_valid", 96'(tx_seen), 96'd1);
            check("R3 tx packet", tx_seen_pkt, e);
            check("R4 byte sum", 96'(8'(sum11(tx_seen_pkt) + tx_seen_pkt[95:88])), 96'd0);
            check("R2 one-shot", 96'(tx_valid), 96'd0);
            read_word(v[73:68]);
            check("R1 readback", 96'(rd), 96'(v[31:0]));
            check("R10 no tx on read", 96'(rd_tx), 96'd0);
            idle(1);
        end

        // R6: broadcast receive, full then partial mask
        send_rx(build(4'h1, 1'b0, 8'd3, 8'd0, 4'hF, 28'd20, 32'hCAFEF00D, 1'b0));
        read_word(6'd20);
        check("R6 full word", 96'(rd), 96'hCAFEF00D);
        idle(1);
        send_rx(build(4'h1, 1'b0, 8'd3, 8'd0, 4'h9, 28'd20, 32'h11223344, 1'b0));
        read_word(6'd20);
        check("R6 masked merge", 96'(rd), 96'h11FEF044);
        idle(1);

        // R5: corrupt data packet dropped and counted
        send_rx(build(4'h1, 1'b0, 8'd3, 8'd0, 4'hF, 28'd20, 32'h00000000, 1'b1));
        read_word(6'd20);
        check("R5 dropped", 96'(rd), 96'h11FEF044);
        check("R5 count", 96'(err_cnt), 96'd1);
        idle(1);

        // R7: unicast to this node and to another node
        send_rx(build(4'h1, 1'b1, 8'd3, NODE, 4'hF, 28'd21, 32'h0A0B0C0D, 1'b0));
        read_word(6'd21);
        check("R7 unicast match", 96'(rd), 96'h0A0B0C0D);
        idle(1);
        send_rx(build(4'h1, 1'b1, 8'd3, 8'd8, 4'hF, 28'd22, 32'h99999999, 1'b0));
        read_word(6'd22);
        check("R7 unicast other", 96'(rd), 96'd0);
        idle(1);

        // R8: non-data packet goes to side output only
        begin
            logic [95:0] sp;
            sp = build(4'h2, 1'b0, 8'd3, 8'd0, 4'hF, 28'd23, 32'h77777777, 1'b0);
            send_rx(sp);
            check("R8 side_valid", 96'(s_valid), 96'd1);
            check("R8 side_pkt", s_pkt, sp);
            check("R8 one-shot", 96'(s_valid_after), 96'd0);
            read_word(6'd23);
            check("R8 mem untouched", 96'(rd), 96'd0);
            idle(1);
            send_rx(build(4'h2, 1'b0, 8'd3, 8'd0, 4'hF, 28'd23, 32'h77777777, 1'b1));
            check("R5 bad side dropped", 96'(s_valid), 96'd0);
            check("R5 count two", 96'(err_cnt), 96'd2);
        end

        // R11: address above the window
        send_rx(build(4'h1, 1'b0, 8'd3, 8'd0, 4'hF, 28'h0000045, 32'h5A5A5A5A, 1'b0));
        read_word(6'd5);
        check("R11 out of window", 96'(rd), 96'd0);
        idle(1);

        // R9: same-cycle collision on one word
        lw_valid = 1'b1; lw_ucast = 0; lw_dest = 0; lw_addr = 6'd30; lw_be = 4'hF; lw_data = 32'h11111111;
        rx_valid = 1'b1;
        rx_pkt = build(4'h1, 1'b0, 8'd3, 8'd0, 4'h3, 28'd30, 32'h2222AAAA, 1'b0);
        @(negedge clk);
        lw_valid = 1'b0; rx_valid = 1'b0;
        check("R9 local packet sent", 96'(tx_valid), 96'd1);
        read_word(6'd30);
        check("R9 local first", 96'(rd), 96'h11111111);
        idle(1);
        read_word(6'd30);
        check("R9 held applied", 96'(rd), 96'h1111AAAA);
        idle(1);

        // R9: collision on different words
        lw_valid = 1'b1; lw_addr = 6'd31; lw_be = 4'hF; lw_data = 32'h33333333;
        rx_valid = 1'b1;
        rx_pkt = build(4'h1, 1'b0, 8'd3, 8'd0, 4'hF, 28'd32, 32'h44444444, 1'b0);
        @(negedge clk);
        lw_valid = 1'b0; rx_valid = 1'b0;
        idle(1);
        read_word(6'd31);
        check("R9 local word", 96'(rd), 96'h33333333);
        idle(1);
        read_word(6'd32);
        check("R9 remote word", 96'(rd), 96'h44444444);
        idle(1);

        // R5: saturation of the error count
        for (int k = 0; k < 300; k++) begin
            send_rx(build(4'h1, 1'b0, 8'd3, 8'd0, 4'hF, 28'd40, 32'(k), 1'b1));
        end
        check("R5 saturate", 96'(err_cnt), 96'(8'hFF));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule